// File: doc/BRIEF.md
# Two-World UART Interrupt Router

This block sits between a UART's event sources and the interrupt controller. It keeps two interrupt status registers, one for the secure world and one for the non-secure world. Each incoming event is steered into one of the two banks. Receiver line events, including an idle timeout that the block detects itself, follow the security of the terminal currently feeding the receiver. FIFO events follow the world that owns the FIFO. The secure bank drives a fast interrupt line (`fiq`) towards the secure world. The non-secure bank drives a normal interrupt line (`irq`) towards the non-secure world.

Software writes reach the block as per-bit set and clear strobes, one pair for each bank; the address decoding is done upstream. A single enable mask gates both banks, because the enable registers belong to the secure world only. Both interrupt outputs are registered levels.

Status bit layout, shared by both banks: bit 0 is the receiver idle timeout, bits 1..NL are the external receiver line events, and bits NL+1..NL+NF are the FIFO events.

Top module: `irq_world_router`

## Requirements
- R1: While `rst_n` is low, both status registers are all zero and `fiq` and `irq` are low.
- R2: With `rx_src_secure`=1, a pulse on `line_ev[k]` sets bit k+1 of `sec_status` on the next clock edge and leaves `ns_status` unchanged.
- R3: With `rx_src_secure`=0, a pulse on `line_ev[k]` sets bit k+1 of `ns_status` and leaves `sec_status` unchanged.
- R4: A pulse on `sec_fifo_ev[j]` sets bit NL+1+j of `sec_status` only, and it never changes `ns_status`.
- R5: A pulse on `ns_fifo_ev[j]` sets bit NL+1+j of `ns_status` only, and it never changes `sec_status`.
- R6: A status bit stays at 1 until a 1 arrives on the same bit of its bank's clear strobe, and it reads 0 after the next edge. When an event or a set strobe hits the same bit in the same cycle as the clear, the bit stays at 1.
- R7: A 1 on a bit of `sec_set` or `ns_set` sets that bit in its own bank only.
- R8: One edge after the status changes, `fiq` equals the OR of `sec_status & int_mask` and `irq` equals the OR of `ns_status & int_mask`. A mask bit of 1 enables its interrupt. The outputs therefore fall in the cycle after the last pending enabled bit clears.
- R9: A pulse on `rx_char` arms the idle timer. Once `rx_timeout_val` ticks of `rx_tick` have passed with no further `rx_char`, exactly one timeout event occurs. It sets status bit 0 and is routed by `rx_src_secure` as in R2 and R3. A value of 0 disables the timer, and the timer does not fire again until the next `rx_char`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_src_secure | input | 1 | 1 when the receiver's current terminal is the secure one |
| rx_char | input | 1 | Pulse: a character was received |
| rx_tick | input | 1 | Pulse: one timeout time unit elapsed |
| rx_timeout_val | input | TW (8) | Idle ticks before a timeout; 0 disables |
| line_ev | input | NL (4) | Receiver line event pulses |
| sec_fifo_ev | input | NF (6) | Event pulses from the secure FIFOs |
| ns_fifo_ev | input | NF (6) | Event pulses from the non-secure FIFOs |
| int_mask | input | W (11) | Interrupt enable mask, 1 = enabled |
| sec_set | input | W (11) | Per-bit set strobes, secure bank |
| sec_clr | input | W (11) | Per-bit clear strobes, secure bank |
| ns_set | input | W (11) | Per-bit set strobes, non-secure bank |
| ns_clr | input | W (11) | Per-bit clear strobes, non-secure bank |
| sec_status | output | W (11) | Secure interrupt status |
| ns_status | output | W (11) | Non-secure interrupt status |
| fiq | output | 1 | Fast interrupt to the secure world |
| irq | output | 1 | Interrupt to the non-secure world |

## Verification
The hardest state to reach is a timeout that fires at the moment the terminal source changes security, with a clear landing on the same bit in that cycle. The timeout comes from a registered pulse produced several ticks after the last character, so that cycle cannot be aimed at directly. Directed sequences count out ticks to place the timeout on a known cycle. Long random runs toggle `rx_src_secure`, characters, ticks and clears at once, and a bench model of the timer and both banks checks every cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef enum logic {
      WORLD_NS  = 1'b0,
      WORLD_SEC = 1'b1
   } world_e;

   // status layout: timeout bit, then line events, then FIFO events
   localparam int TIMEOUT_BIT = 0;

   function automatic int stat_width(input int nl, input int nf);
      return 1 + nl + nf;
   endfunction

   function automatic int fifo_base(input int nl);
      return 1 + nl;
   endfunction

endpackage

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_char,
   input  logic          rx_tick,
   input  logic [TW-1:0] limit,
   output logic          timeout_pulse
);

   if (TW < 1) begin : g_bad_tw
      $error("rx_idle_timer: TW must be at least 1");
   end

   logic [TW-1:0] cnt;
   logic          armed;
   logic [TW-1:0] limit_m1;
   logic          limit_zero;
   logic          expire;

   assign limit_zero = (limit == '0);
   assign limit_m1   = limit - {{(TW-1){1'b0}}, 1'b1};
   assign expire     = armed & rx_tick & ~rx_char & ~limit_zero & (cnt >= limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt           <= '0;
         armed         <= 1'b0;
         timeout_pulse <= 1'b0;
      end else begin
         timeout_pulse <= expire;
         if (rx_char) begin
            cnt   <= '0;
            armed <= 1'b1;
         end else if (expire) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else if (armed && rx_tick) begin
            cnt <= cnt + {{(TW-1){1'b0}}, 1'b1};
         end
      end
   end

endmodule

// File: rtl/event_router.sv
module event_router #(
   parameter int NL = 4,
   parameter int NF = 6,
   localparam int W  = irq_route_pkg::stat_width(NL, NF),
   localparam int FB = irq_route_pkg::fifo_base(NL)
) (
   input  logic          src_secure,
   input  logic [NL:0]   line_all,
   input  logic [NF-1:0] sec_fifo_ev,
   input  logic [NF-1:0] ns_fifo_ev,
   output logic [W-1:0]  sec_ev,
   output logic [W-1:0]  ns_ev
);

   import irq_route_pkg::*;

   world_e line_world;
   assign line_world = src_secure ? WORLD_SEC : WORLD_NS;

   // receiver line events follow the terminal source
   for (genvar k = 0; k <= NL; k++) begin : g_line
      assign sec_ev[k] = line_all[k] & (line_world == WORLD_SEC);
      assign ns_ev[k]  = line_all[k] & (line_world == WORLD_NS);
   end

   // FIFO events follow the owning world only
   for (genvar j = 0; j < NF; j++) begin : g_fifo
      assign sec_ev[FB+j] = sec_fifo_ev[j];
      assign ns_ev[FB+j]  = ns_fifo_ev[j];
   end

endmodule

// File: rtl/status_bank.sv
module status_bank #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] status
);

   if (W < 2) begin : g_bad_w
      $error("status_bank: W must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic raise;
      assign raise = ev[i] | set_bits[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status[i] <= 1'b0;
         end else if (raise) begin
            status[i] <= 1'b1;
         end else if (clr_bits[i]) begin
            status[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
   parameter int W       = 11,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   output logic         req
);

   logic pend;
   assign pend = |(status & mask);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req <= 1'b0;
         else        req <= pend;
      end
   end else begin : g_comb
      assign req = pend;
   end

endmodule

// File: rtl/irq_world_router.sv
module irq_world_router #(
   parameter int NL = 4,
   parameter int NF = 6,
   parameter int TW = 8,
   localparam int W = irq_route_pkg::stat_width(NL, NF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_src_secure,
   input  logic          rx_char,
   input  logic          rx_tick,
   input  logic [TW-1:0] rx_timeout_val,
   input  logic [NL-1:0] line_ev,
   input  logic [NF-1:0] sec_fifo_ev,
   input  logic [NF-1:0] ns_fifo_ev,
   input  logic [W-1:0]  int_mask,
   input  logic [W-1:0]  sec_set,
   input  logic [W-1:0]  sec_clr,
   input  logic [W-1:0]  ns_set,
   input  logic [W-1:0]  ns_clr,
   output logic [W-1:0]  sec_status,
   output logic [W-1:0]  ns_status,
   output logic          fiq,
   output logic          irq
);

   if (NL < 1 || NF < 1) begin : g_bad_counts
      $error("irq_world_router: NL and NF must be at least 1");
   end

   logic          to_pulse;
   logic [NL:0]   line_all;
   logic [W-1:0]  sec_ev;
   logic [W-1:0]  ns_ev;

   rx_idle_timer #(.TW(TW)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_char       (rx_char),
      .rx_tick       (rx_tick),
      .limit         (rx_timeout_val),
      .timeout_pulse (to_pulse)
   );

   assign line_all = {line_ev, to_pulse};

   event_router #(.NL(NL), .NF(NF)) u_route (
      .src_secure  (rx_src_secure),
      .line_all    (line_all),
      .sec_fifo_ev (sec_fifo_ev),
      .ns_fifo_ev  (ns_fifo_ev),
      .sec_ev      (sec_ev),
      .ns_ev       (ns_ev)
   );

   status_bank #(.W(W)) u_sec_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (sec_ev),
      .set_bits (sec_set),
      .clr_bits (sec_clr),
      .status   (sec_status)
   );

   status_bank #(.W(W)) u_ns_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ns_ev),
      .set_bits (ns_set),
      .clr_bits (ns_clr),
      .status   (ns_status)
   );

   irq_reduce #(.W(W), .REG_OUT(1'b1)) u_fiq (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (sec_status),
      .mask   (int_mask),
      .req    (fiq)
   );

   irq_reduce #(.W(W), .REG_OUT(1'b1)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (ns_status),
      .mask   (int_mask),
      .req    (irq)
   );

endmodule

// File: rtl/irq_world_router_chk.sv
module irq_world_router_chk #(
   parameter int NL = 4,
   parameter int NF = 6,
   localparam int W  = irq_route_pkg::stat_width(NL, NF),
   localparam int FB = irq_route_pkg::fifo_base(NL)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_src_secure,
   input logic [NL-1:0] line_ev,
   input logic [NF-1:0] sec_fifo_ev,
   input logic [NF-1:0] ns_fifo_ev,
   input logic [W-1:0]  int_mask,
   input logic [W-1:0]  sec_set,
   input logic [W-1:0]  sec_clr,
   input logic [W-1:0]  ns_set,
   input logic [W-1:0]  sec_ev,
   input logic [W-1:0]  sec_status,
   input logic [W-1:0]  ns_status,
   input logic          to_pulse,
   input logic          fiq,
   input logic          irq
);

   logic [W-1:0] sfe_w, nfe_w, line_w, fifo_field;
   assign sfe_w      = W'(sec_fifo_ev) << FB;
   assign nfe_w      = W'(ns_fifo_ev) << FB;
   assign line_w     = W'(line_ev) << 1;
   assign fifo_field = {W{1'b1}} << FB;

   assert_fiq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sec_status & int_mask)) |=> fiq);
   assert_fiq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sec_status & int_mask)) |=> !fiq);
   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ns_status & int_mask)) |=> irq);
   assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(ns_status & int_mask)) |=> !irq);

   assert_line_secure_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_src_secure && (|line_ev)) |=> ((sec_status & $past(line_w)) == $past(line_w)));

   assert_sec_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|sec_fifo_ev) |=> ((sec_status & $past(sfe_w)) == $past(sfe_w)));

   // FIFO field of the non-secure bank rises only from its own FIFO or set strobe
   assert_ns_fifo_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ns_status == ns_status) |=>
      ((ns_status & ~$past(ns_status) & ~$past(nfe_w | ns_set) & fifo_field) == '0));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|sec_clr) |=> ((sec_status & $past(sec_clr & ~sec_ev & ~sec_set)) == '0));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sec_status & ~sec_clr)) |=> ((~sec_status & $past(sec_status & ~sec_clr)) == '0));

   assert_single_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
      to_pulse |=> !to_pulse);

endmodule

bind irq_world_router irq_world_router_chk #(.NL(NL), .NF(NF)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_src_secure (rx_src_secure),
   .line_ev       (line_ev),
   .sec_fifo_ev   (sec_fifo_ev),
   .ns_fifo_ev    (ns_fifo_ev),
   .int_mask      (int_mask),
   .sec_set       (sec_set),
   .sec_clr       (sec_clr),
   .ns_set        (ns_set),
   .sec_ev        (sec_ev),
   .sec_status    (sec_status),
   .ns_status     (ns_status),
   .to_pulse      (to_pulse),
   .fiq           (fiq),
   .irq           (irq)
);

// File: tb/irq_world_router_test.sv
`timescale 1ns/1ps
module irq_world_router_test;

   localparam int NL = 4;
   localparam int NF = 6;
   localparam int TW = 8;
   localparam int W  = 1 + NL + NF;
   localparam int FB = 1 + NL;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx_src_secure, rx_char, rx_tick;
   logic [TW-1:0] rx_timeout_val;
   logic [NL-1:0] line_ev;
   logic [NF-1:0] sec_fifo_ev, ns_fifo_ev;
   logic [W-1:0]  int_mask, sec_set, sec_clr, ns_set, ns_clr;
   logic [W-1:0]  sec_status, ns_status;
   logic          fiq, irq;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // model state
   logic [W-1:0]  m_sec, m_ns;
   logic          m_fiq, m_irq, m_to, m_armed;
   logic [TW-1:0] m_cnt;

   always #5 clk = ~clk;

   irq_world_router #(.NL(NL), .NF(NF), .TW(TW)) uut (.*);

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      rx_char = 0; rx_tick = 0; line_ev = '0; sec_fifo_ev = '0; ns_fifo_ev = '0;
      sec_set = '0; sec_clr = '0; ns_set = '0; ns_clr = '0;
   endtask

   function automatic logic [W-1:0] route(input logic sec_side);
      logic [W-1:0] lines;
      lines = {W'(line_ev) << 1} | W'(m_to);
      if (sec_side) return (rx_src_secure ? lines : '0) | (W'(sec_fifo_ev) << FB);
      else          return (rx_src_secure ? '0 : lines) | (W'(ns_fifo_ev) << FB);
   endfunction

   // one clock: compute the model's next state from current inputs, then advance
   task automatic cyc();
      logic [W-1:0]  n_sec, n_ns;
      logic          n_fiq, n_irq, n_to, n_armed, fire;
      logic [TW-1:0] n_cnt;
      n_fiq = |(m_sec & int_mask);
      n_irq = |(m_ns & int_mask);
      n_sec = (m_sec & ~sec_clr) | route(1'b1) | sec_set;
      n_ns  = (m_ns & ~ns_clr) | route(1'b0) | ns_set;
      fire  = m_armed && rx_tick && !rx_char && rx_timeout_val != 0 &&
              (m_cnt >= rx_timeout_val - 1);
      n_to = fire; n_armed = m_armed; n_cnt = m_cnt;
      if (rx_char) begin n_cnt = 0; n_armed = 1; end
      else if (fire) begin n_cnt = 0; n_armed = 0; end
      else if (m_armed && rx_tick) n_cnt = m_cnt + 1;
      @(posedge clk);
      m_sec = n_sec; m_ns = n_ns; m_fiq = n_fiq; m_irq = n_irq;
      m_to = n_to; m_armed = n_armed; m_cnt = n_cnt;
      @(negedge clk);
   endtask

   task automatic pulse_cyc();
      cyc();
      idle_inputs();
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; idle_inputs(); rx_src_secure = 1; rx_timeout_val = 0; int_mask = '1;
      m_sec = 0; m_ns = 0; m_fiq = 0; m_irq = 0; m_to = 0; m_armed = 0; m_cnt = 0;
      sec_set = '1; ns_set = '1;              // set strobes held in reset must not matter
      repeat (3) @(negedge clk);
      check("R1 sec_status", sec_status, '0);
      check("R1 ns_status", ns_status, '0);
      check("R1 fiq/irq", {9'd0, fiq, irq}, '0);
      idle_inputs();
      rst_n = 1;
      @(negedge clk);

      // R2: secure-terminal line event, with one-cycle output latency (R8)
      rx_src_secure = 1; line_ev = 4'b0010; pulse_cyc();
      check("R2 sec_status", sec_status, 11'h004);
      check("R2 ns untouched", ns_status, '0);
      check("R8 fiq not yet", W'(fiq), '0);
      cyc();
      check("R8 fiq high", W'(fiq), 11'h001);
      check("R8 irq low", W'(irq), '0);

      // R6: clear, then fiq drops one cycle later
      sec_clr = 11'h004; pulse_cyc();
      check("R6 cleared", sec_status, '0);
      check("R8 fiq still high", W'(fiq), 11'h001);
      cyc();
      check("R8 fiq fallen", W'(fiq), '0);

      // R3: non-secure terminal line event
      rx_src_secure = 0; line_ev = 4'b1000; pulse_cyc(); cyc();
      check("R3 ns_status", ns_status, 11'h010);
      check("R3 sec untouched", sec_status, '0);
      check("R8 irq high", W'(irq), 11'h001);
      ns_clr = '1; pulse_cyc(); cyc();

      // R4 / R5: FIFO events follow ownership whatever the terminal source
      rx_src_secure = 0; sec_fifo_ev = 6'b000001; ns_fifo_ev = 6'b100000; pulse_cyc();
      check("R4 sec fifo bit", sec_status, 11'h020);
      check("R5 ns fifo bit", ns_status, 11'h400);
      sec_clr = '1; ns_clr = '1; pulse_cyc();

      // R6: event and clear on the same bit in the same cycle, event wins
      sec_fifo_ev = 6'b000100; pulse_cyc();
      sec_fifo_ev = 6'b000100; sec_clr = 11'h080; pulse_cyc();
      check("R6 event beats clear", sec_status, 11'h080);
      sec_set = 11'h001; sec_clr = 11'h001; pulse_cyc();
      check("R6 set beats clear", sec_status, 11'h081);
      sec_clr = '1; pulse_cyc(); cyc();

      // R7: set strobes stay in their bank; R8 mask gates output
      ns_set = 11'h002; int_mask = 11'h7FD; pulse_cyc(); cyc();
      check("R7 ns set", ns_status, 11'h002);
      check("R7 sec untouched", sec_status, '0);
      check("R8 masked irq", W'(irq), '0);
      int_mask = '1; cyc(); cyc();
      check("R8 unmasked irq", W'(irq), 11'h001);
      ns_clr = '1; pulse_cyc(); cyc();

      // R9: timeout after 3 ticks, secure terminal
      rx_src_secure = 1; rx_timeout_val = 3;
      rx_char = 1; pulse_cyc();
      for (int t = 0; t < 2; t++) begin rx_tick = 1; pulse_cyc(); cyc(); end
      repeat (3) cyc();
      check("R9 no early timeout", sec_status, '0);
      rx_tick = 1; pulse_cyc(); repeat (3) cyc();
      check("R9 timeout secure", sec_status, 11'h001);
      check("R9 fiq", W'(fiq), 11'h001);
      sec_clr = '1; pulse_cyc();
      for (int t = 0; t < 5; t++) begin rx_tick = 1; pulse_cyc(); end
      repeat (2) cyc();
      check("R9 no refire", sec_status, '0);
      // non-secure terminal
      rx_src_secure = 0; rx_char = 1; pulse_cyc();
      for (int t = 0; t < 3; t++) begin rx_tick = 1; pulse_cyc(); end
      repeat (2) cyc();
      check("R9 timeout non-secure", ns_status, 11'h001);
      check("R9 sec untouched", sec_status, '0);
      ns_clr = '1; pulse_cyc();
      // disabled
      rx_timeout_val = 0; rx_char = 1; pulse_cyc();
      for (int t = 0; t < 6; t++) begin rx_tick = 1; pulse_cyc(); end
      repeat (2) cyc();
      check("R9 disabled", ns_status, '0);

      // random phase against the model
      for (int n = 0; n < 4000; n++) begin
         rx_src_secure = ($urandom % 8 == 0) ? ~rx_src_secure : rx_src_secure;
         rx_char = ($urandom % 20 == 0);
         rx_tick = ($urandom % 3 == 0);
         if ($urandom % 200 == 0) rx_timeout_val = TW'($urandom % 6);
         if ($urandom % 50 == 0)  int_mask = W'($urandom);
         line_ev     = NL'($urandom & $urandom & $urandom);
         sec_fifo_ev = NF'($urandom & $urandom & $urandom);
         ns_fifo_ev  = NF'($urandom & $urandom & $urandom);
         sec_set = ($urandom % 10 == 0) ? W'($urandom & $urandom) : '0;
         ns_set  = ($urandom % 10 == 0) ? W'($urandom & $urandom) : '0;
         sec_clr = ($urandom % 4 == 0) ? W'($urandom) : '0;
         ns_clr  = ($urandom % 4 == 0) ? W'($urandom) : '0;
         cyc();
         check("R6 random sec_status", sec_status, m_sec);
         check("R6 random ns_status", ns_status, m_ns);
         check("R8 random fiq", W'(fiq), W'(m_fiq));
         check("R8 random irq", W'(irq), W'(m_irq));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule